// File: doc/BRIEF.md
# Blitter Command Queue and Decoder

This block is the command front end of a 2D drawing engine. A host builds each 32-bit command from two 16-bit register writes: the upper half goes to a holding register first, and the write of the lower half pushes the whole word into a command queue. The block takes words off the queue one per cycle and decodes the opcode in bits 31:24. Parameter opcodes load a masked payload into one of the drawing parameters. Go opcodes start the engine and halt further decoding until the engine reports that it has finished.

The block also reports how many words are still pending, lets the host clear the queue, and keeps a completion status with write-one-to-clear bits. The status feeds an interrupt output through an enable mask. It never touches pixel memory. It only presents parameters, an operation select and a start pulse to the engine, and waits for a done pulse back.

Top module: `blit_cmd_front`

## Requirements
- R1: After reset, pending_o is 0, all parameter outputs are 0, irq_status_o is 0, irq_o is 0 and eng_start_o is 0.
- R2: A host write to select 0 stores the upper 16 bits. A write to select 1 pushes {upper, data} into the queue, and pending_o is one higher on the cycle after that write.
- R3: Opcode 0x0C loads dst_addr_o and opcode 0x0D loads src_addr_o, each taking payload bits 23:1 with bit 0 forced to 0.
- R4: Opcode 0x0E loads width_o and opcode 0x0F loads height_o from payload bits 9:0. Opcode 0x0B loads color_o from payload bits 15:0.
- R5: Opcode 0x23 starts a fill (eng_op_o = 0) and opcode 0x21 starts a copy (eng_op_o = 1). Each raises eng_start_o for exactly one cycle and sets eng_last_o from payload bit 0. No later word is decoded until eng_done_i arrives.
- R6: pending_o equals the number of queued words plus one while an operation is in flight. For a go command the count drops only in the cycle after eng_done_i.
- R7: A word with any other opcode is removed from the queue and changes no output apart from pending_o.
- R8: The queue holds DEPTH words. A low-half write while DEPTH words are queued is dropped.
- R9: A write to select 2 with data bit 0 set empties the queue without affecting an operation in flight. With bit 0 clear the write has no effect.
- R10: When an operation completes, irq_status_o bit 0 sets, and bit 1 also sets if the go payload had bit 1 set. A write to select 3 clears the bits that are 1 in the data. A bit being set in the same cycle stays set.
- R11: Select 4 loads a 2-bit enable mask, and irq_o is high exactly when some status bit and its enable bit are both 1.
- R12: eng_done_i while no operation is in flight has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 3 | Register select: 0 upper half, 1 lower half and push, 2 clear, 3 status clear, 4 enable |
| wr_data_i | input | 16 | Host write data |
| pending_o | output | $clog2(DEPTH+2) | Queued words plus in-flight operation |
| irq_status_o | output | 2 | Completion status: bit 0 any, bit 1 requested |
| irq_o | output | 1 | Masked interrupt |
| eng_start_o | output | 1 | One-cycle engine start |
| eng_op_o | output | 1 | 0 fill, 1 copy |
| eng_last_o | output | 1 | Command-end flag of the current go |
| eng_done_i | input | 1 | Engine completion pulse |
| dst_addr_o | output | ADDR_W | Destination start address |
| src_addr_o | output | ADDR_W | Source start address |
| width_o | output | PIX_W | Width minus one |
| height_o | output | PIX_W | Height minus one |
| color_o | output | COLOR_W | Fill colour |

## Verification
The hardest state to reach is a completely full queue sitting behind an operation in flight. Only there does the dropped-write rule apply, with pending_o at DEPTH+1. The stimulus starts a fill and holds the engine stub's done back. It then pushes DEPTH parameter words plus one extra word, checks that the extra word never reaches height_o, and releases the engine so the backlog drains. The queue clear is exercised the same way, behind a held operation, so the bench can show that the in-flight operation survives the clear.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int CMD_W = 32;

  typedef enum logic [2:0] {
    REG_CMD_HI   = 3'd0,
    REG_CMD_LO   = 3'd1,
    REG_FIFO_CLR = 3'd2,
    REG_IRQ_STAT = 3'd3,
    REG_IRQ_EN   = 3'd4
  } reg_sel_e;

  localparam logic [7:0] OP_COLOR  = 8'h0B;
  localparam logic [7:0] OP_DST    = 8'h0C;
  localparam logic [7:0] OP_SRC    = 8'h0D;
  localparam logic [7:0] OP_WIDTH  = 8'h0E;
  localparam logic [7:0] OP_HEIGHT = 8'h0F;
  localparam logic [7:0] OP_COPY   = 8'h21;
  localparam logic [7:0] OP_FILL   = 8'h23;

  typedef enum logic {
    ENG_FILL = 1'b0,
    ENG_COPY = 1'b1
  } eng_op_e;
endpackage

// File: rtl/blit_cmd_fifo.sv
module blit_cmd_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // full check uses the current count only
  assign push_ok = push_i && (cnt_q != FULL);
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign valid_o = (cnt_q != '0);
  assign head_o  = mem[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= bump(wptr_q);
      if (pop_ok)  rptr_q <= bump(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/blit_cmd_decode.sv
module blit_cmd_decode
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int PIX_W   = 10,
  parameter int COLOR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CMD_W-1:0]   head_i,
  input  logic               valid_i,
  input  logic               eng_done_i,
  output logic               pop_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               done_irq_o,
  output logic               start_o,
  output eng_op_e            op_o,
  output logic               last_o,
  output logic [ADDR_W-1:0]  dst_o,
  output logic [ADDR_W-1:0]  src_o,
  output logic [PIX_W-1:0]   width_o,
  output logic [PIX_W-1:0]   height_o,
  output logic [COLOR_W-1:0] color_o
);
  logic [7:0]         opc;
  logic [ADDR_W-1:0]  addr_pl;
  logic               busy_q, start_q, last_q, irq_req_q;
  eng_op_e            op_q;
  logic [ADDR_W-1:0]  dst_q, src_q;
  logic [PIX_W-1:0]   w_q, h_q;
  logic [COLOR_W-1:0] col_q;

  assign opc     = head_i[31:24];
  assign addr_pl = {head_i[ADDR_W-1:1], 1'b0};
  assign pop_o   = valid_i && !busy_q;
  assign done_o  = busy_q && eng_done_i;
  assign done_irq_o = done_o && irq_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      start_q   <= 1'b0;
      last_q    <= 1'b0;
      irq_req_q <= 1'b0;
      op_q      <= ENG_FILL;
      dst_q     <= '0;
      src_q     <= '0;
      w_q       <= '0;
      h_q       <= '0;
      col_q     <= '0;
    end else begin
      start_q <= 1'b0;
      if (done_o) busy_q <= 1'b0;
      if (pop_o) begin
        unique case (opc)
          OP_DST:    dst_q <= addr_pl;
          OP_SRC:    src_q <= addr_pl;
          OP_WIDTH:  w_q   <= head_i[PIX_W-1:0];
          OP_HEIGHT: h_q   <= head_i[PIX_W-1:0];
          OP_COLOR:  col_q <= head_i[COLOR_W-1:0];
          OP_FILL, OP_COPY: begin
            busy_q    <= 1'b1;
            start_q   <= 1'b1;
            op_q      <= (opc == OP_COPY) ? ENG_COPY : ENG_FILL;
            last_q    <= head_i[0];
            irq_req_q <= head_i[1];
          end
          default: ;  // discarded
        endcase
      end
    end
  end

  assign busy_o   = busy_q;
  assign start_o  = start_q;
  assign op_o     = op_q;
  assign last_o   = last_q;
  assign dst_o    = dst_q;
  assign src_o    = src_q;
  assign width_o  = w_q;
  assign height_o = h_q;
  assign color_o  = col_q;
endmodule

// File: rtl/blit_irq_ctrl.sv
module blit_irq_ctrl #(
  parameter int IRQ_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic             en_we_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] status_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] stat_q, en_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | set_i;  // set wins
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = |(stat_q & en_q);
endmodule

// File: rtl/blit_cmd_front.sv
module blit_cmd_front
  import blit_pkg::*;
#(
  parameter int DEPTH   = 512,
  parameter int ADDR_W  = 24,
  parameter int PIX_W   = 10,
  parameter int COLOR_W = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PEND_W = $clog2(DEPTH + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [15:0]        wr_data_i,
  output logic [PEND_W-1:0]  pending_o,
  output logic [1:0]         irq_status_o,
  output logic               irq_o,
  output logic               eng_start_o,
  output logic               eng_op_o,
  output logic               eng_last_o,
  input  logic               eng_done_i,
  output logic [ADDR_W-1:0]  dst_addr_o,
  output logic [ADDR_W-1:0]  src_addr_o,
  output logic [PIX_W-1:0]   width_o,
  output logic [PIX_W-1:0]   height_o,
  output logic [COLOR_W-1:0] color_o
);
  logic [15:0]      hi_q;
  logic             push, clear, pop, valid, busy, done, done_irq;
  logic [CMD_W-1:0] head;
  logic [CNT_W-1:0] count;
  eng_op_e          op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else if (wr_en_i && wr_addr_i == REG_CMD_HI) hi_q <= wr_data_i;
  end

  assign push  = wr_en_i && (wr_addr_i == REG_CMD_LO);
  assign clear = wr_en_i && (wr_addr_i == REG_FIFO_CLR) && wr_data_i[0];

  blit_cmd_fifo #(.DEPTH(DEPTH), .W(CMD_W)) u_fifo (
    .clk_i, .rst_ni,
    .clear_i     (clear),
    .push_i      (push),
    .push_data_i ({hi_q, wr_data_i}),
    .pop_i       (pop),
    .head_o      (head),
    .valid_o     (valid),
    .count_o     (count)
  );

  blit_cmd_decode #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .COLOR_W(COLOR_W)) u_dec (
    .clk_i, .rst_ni,
    .head_i     (head),
    .valid_i    (valid),
    .eng_done_i (eng_done_i),
    .pop_o      (pop),
    .busy_o     (busy),
    .done_o     (done),
    .done_irq_o (done_irq),
    .start_o    (eng_start_o),
    .op_o       (op),
    .last_o     (eng_last_o),
    .dst_o      (dst_addr_o),
    .src_o      (src_addr_o),
    .width_o    (width_o),
    .height_o   (height_o),
    .color_o    (color_o)
  );

  blit_irq_ctrl #(.IRQ_W(2)) u_irq (
    .clk_i, .rst_ni,
    .set_i    ({done_irq, done}),
    .clr_we_i (wr_en_i && wr_addr_i == REG_IRQ_STAT),
    .en_we_i  (wr_en_i && wr_addr_i == REG_IRQ_EN),
    .wdata_i  (wr_data_i[1:0]),
    .status_o (irq_status_o),
    .irq_o    (irq_o)
  );

  assign eng_op_o  = op;
  assign pending_o = PEND_W'(count) + PEND_W'(busy);
endmodule

// File: rtl/blit_cmd_front_chk.sv
module blit_cmd_front_chk
  import blit_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int PEND_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [2:0]        wr_addr_i,
  input logic [15:0]       wr_data_i,
  input logic [PEND_W-1:0] pending_o,
  input logic [1:0]        irq_status_o,
  input logic              eng_start_o,
  input logic              eng_done_i
);
  a_r5_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  a_r6_inflight_counted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (pending_o != '0));

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o <= PEND_W'(DEPTH + 1));

  a_r2_push_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_CMD_LO && pending_o == '0) |=> (pending_o == PEND_W'(1)));

  a_r9_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_FIFO_CLR && wr_data_i[0]) |=> (pending_o <= PEND_W'(1)));

  a_r10_set_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_status_o[0]) |-> $past(eng_done_i));
endmodule

bind blit_cmd_front blit_cmd_front_chk #(.DEPTH(DEPTH), .PEND_W(PEND_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .pending_o    (pending_o),
  .irq_status_o (irq_status_o),
  .eng_start_o  (eng_start_o),
  .eng_done_i   (eng_done_i)
);

// File: tb/sim_blit_cmd_front.sv
module sim_blit_cmd_front;
  localparam int DEPTH  = 512;
  localparam int PEND_W = $clog2(DEPTH + 2);

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic stub_done = 0, stray = 0, eng_done;
  logic [PEND_W-1:0] pending;
  logic [1:0] stat;
  logic irq, start, op, last;
  logic [23:0] dst, src;
  logic [9:0] wid, hgt;
  logic [15:0] col;

  int n_chk = 0, n_fail = 0;
  int lat = 4, cnt = 0;
  bit hold = 0, over = 0;

  always #10 clk = ~clk;
  assign eng_done = stub_done | stray;

  blit_cmd_front #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pending_o(pending), .irq_status_o(stat), .irq_o(irq),
    .eng_start_o(start), .eng_op_o(op), .eng_last_o(last), .eng_done_i(eng_done),
    .dst_addr_o(dst), .src_addr_o(src), .width_o(wid), .height_o(hgt), .color_o(col));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // engine stub
  always @(negedge clk) begin
    if (!rst_ni) begin cnt = 0; stub_done = 0; end
    else if (start) begin cnt = lat; stub_done = 0; end
    else if (cnt > 0 && !hold) begin cnt--; stub_done = (cnt == 0); end
    else stub_done = 0;
  end

  // reference model
  logic [31:0] q[$];
  bit m_exec, m_irqreq, m_start, m_op, m_last;
  logic [15:0] m_hi, m_col;
  logic [23:0] m_dst, m_src;
  logic [9:0] m_w, m_h;
  logic [1:0] m_stat, m_en;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      m_exec = 0; m_irqreq = 0; m_start = 0; m_op = 0; m_last = 0;
      m_hi = 0; m_col = 0; m_dst = 0; m_src = 0; m_w = 0; m_h = 0;
      m_stat = 0; m_en = 0;
    end else begin
      bit old_exec;
      int old_size;
      logic [1:0] set, clr;
      logic [31:0] w;
      old_exec = m_exec; old_size = q.size(); set = 0; clr = 0; m_start = 0;
      if (old_exec && eng_done) begin m_exec = 0; set = {m_irqreq, 1'b1}; end
      if (!old_exec && old_size > 0) begin
        w = q.pop_front();
        case (w[31:24])
          8'h0C: m_dst = {w[23:1], 1'b0};
          8'h0D: m_src = {w[23:1], 1'b0};
          8'h0E: m_w = w[9:0];
          8'h0F: m_h = w[9:0];
          8'h0B: m_col = w[15:0];
          8'h21, 8'h23: begin
            m_exec = 1; m_start = 1; m_op = (w[31:24] == 8'h21);
            m_last = w[0]; m_irqreq = w[1];
          end
          default: ;
        endcase
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_hi = wr_data;
          3'd1: if (old_size < DEPTH) q.push_back({m_hi, wr_data});
          3'd2: if (wr_data[0]) q.delete();
          3'd3: clr = wr_data[1:0];
          3'd4: m_en = wr_data[1:0];
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clr) | set;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_ni && !over) begin
      chk("R6 pending", pending, q.size() + m_exec);
      chk("R10 status", stat, m_stat);
      chk("R11 irq", irq, |(m_stat & m_en));
      chk("R5 start", start, m_start);
      chk("R5 op", op, m_op);
      chk("R5 last", last, m_last);
      chk("R3 dst", dst, m_dst);
      chk("R3 src", src, m_src);
      chk("R4 width", wid, m_w);
      chk("R4 height", hgt, m_h);
      chk("R4 color", col, m_col);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic push_cmd(input logic [31:0] c);
    wr(3'd0, c[31:16]);
    wr(3'd1, c[15:0]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    over = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    // R1 reset values
    chk("R1 pending", pending, 0);
    chk("R1 dst", dst, 0);
    chk("R1 status", stat, 0);
    chk("R1 irq", irq, 0);
    chk("R1 start", start, 0);
    rst_ni = 1;
    idle(2);

    // R2 R3 R4 parameter loads and masks
    push_cmd(32'h0CAB_CDEF); idle(2); chk("R3 dst mask", dst, 24'hABCDEE);
    push_cmd(32'h0DFF_FFFF); idle(2); chk("R3 src mask", src, 24'hFFFFFE);
    push_cmd(32'h0E00_FFFF); idle(2); chk("R4 width mask", wid, 10'h3FF);
    push_cmd(32'h0F00_0123); idle(2); chk("R4 height", hgt, 10'h123);
    push_cmd(32'h0B34_5678); idle(2); chk("R4 color", col, 16'h5678);
    wr(3'd0, 16'h0C00); wr(3'd1, 16'h0000);
    chk("R2 pending after low write", pending, 1);
    idle(2); chk("R2 word assembled", dst, 0);
    push_cmd(32'h0CAB_CDEF); idle(2);

    // R7 unknown opcode
    push_cmd(32'h55FF_FFFF); idle(2);
    chk("R7 dst kept", dst, 24'hABCDEE);
    chk("R7 drained", pending, 0);

    // R5 R10 R11 fill with interrupt request
    wr(3'd4, 16'h0003);
    push_cmd(32'h2300_0003); idle(1);
    chk("R5 start pulse", start, 1);
    chk("R5 fill op", op, 0);
    idle(lat + 4);
    chk("R10 both bits", stat, 2'b11);
    chk("R11 irq on", irq, 1);
    wr(3'd3, 16'h0001); idle(1);
    chk("R10 w1c bit0", stat, 2'b10);
    wr(3'd4, 16'h0001); idle(1);
    chk("R11 masked", irq, 0);
    wr(3'd3, 16'h0002); idle(1);
    chk("R10 w1c bit1", stat, 2'b00);

    // R5 R6 copy stalls later words
    hold = 1;
    push_cmd(32'h2100_0001);
    push_cmd(32'h0C00_0010); idle(4);
    chk("R6 in flight plus queued", pending, 2);
    chk("R5 stalled", dst, 24'hABCDEE);
    chk("R5 copy op", op, 1);
    hold = 0; idle(lat + 4);
    chk("R5 resumed", dst, 24'h000010);
    chk("R10 bit0 only", stat, 2'b01);
    wr(3'd3, 16'h0003);

    // R12 stray done
    stray = 1; idle(1); stray = 0; idle(2);
    chk("R12 ignored", stat, 0);

    // R8 full queue behind held operation
    lat = 1; hold = 1;
    push_cmd(32'h2300_0000); idle(3);
    for (int i = 0; i < DEPTH; i++) push_cmd(32'h0E00_0000 | i);
    chk("R8 full", pending, DEPTH + 1);
    push_cmd(32'h0F00_0055);
    chk("R8 drop", pending, DEPTH + 1);
    hold = 0; idle(DEPTH + 10);
    chk("R8 drained", pending, 0);
    chk("R8 last width", wid, 10'((DEPTH - 1) & 10'h3FF));
    chk("R8 dropped word", hgt, 10'h123);

    // R9 clear
    wr(3'd2, 16'h0000); idle(1);
    chk("R9 bit0 clear no effect", pending, 0);
    hold = 1; lat = 3;
    push_cmd(32'h2100_0000); idle(3);
    for (int i = 0; i < 5; i++) push_cmd(32'h0C00_0100 | i);
    wr(3'd2, 16'h0000); idle(1);
    chk("R9 ignored", pending, 6);
    wr(3'd2, 16'h0001); idle(1);
    chk("R9 cleared", pending, 1);
    hold = 0; idle(lat + 4);
    chk("R9 in flight kept", pending, 0);
    chk("R9 params intact", dst, 24'h000010);
    chk("R9 op completed", stat[0], 1);

    // R10 set and clear in the same cycle
    wr(3'd3, 16'h0003);
    lat = 2; hold = 0;
    push_cmd(32'h2300_0000); idle(2);
    wr(3'd3, 16'h0001); idle(3);
    chk("R10 set wins or later", stat[0], 1);
    idle(2);
    finish_run();
  end
endmodule